// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This watchdog counts down on its own slow clock. Software talks to it only through a small bus-side register window, and the counting side runs independently of the bus clock. Fixed 16-bit key values written to a key register start the counter, refresh it from the reload value, and open the two configuration registers for writing. Once the watchdog is running, nothing can stop it. If the count reaches zero, a reset request is raised and held until the block is reset.

Every command and configuration change moves from the bus clock to the watchdog clock through a toggle handshake. While a prescaler or reload update is still crossing, a status flag shows it. A strap input can start the watchdog in hardware. A debug-halt input can freeze the count, but only when a freeze-enable input allows it. The halt and freeze-enable inputs are treated as synchronous to the watchdog clock.

Top module: `keyed_wdt`

## Requirements
- R1: Writing key 0xCCCC to address 0 starts the watchdog. After the start lands, the 12-bit counter runs down from 0xFFF. Expiry comes after 4095 prescaled ticks.
- R2: When a running counter reaches zero, `rst_req_o` goes high. It stays high, through refresh keys as well, until `rst_ni` is asserted.
- R3: Writing key 0xAAAA to address 0 loads the reload value into the counter and restarts the prescaler. Refreshes spaced shorter than the timeout keep `rst_req_o` low.
- R4: Writes to the prescaler register (address 1, bits [2:0]) and the reload register (address 2, bits [11:0]) take effect only after key 0x5555. Any other key write closes access again. While access is closed, writes to these two registers leave their read-back unchanged.
- R5: Once started, no key value and no other register write stops the counter.
- R6: A high `hw_start_i` starts the watchdog without any key write. The count runs from 0xFFF.
- R7: Status (address 3) bit 0 is high while a prescaler update crosses to the watchdog clock. Bit 1 does the same for a reload update. Each flag is high from the cycle after the accepted write. A write to the same register while its flag is high is ignored.
- R8: Prescaler code n divides the watchdog clock by 4·2^n. Codes 6 and 7 both divide by 256. A refresh with reload value R expires after R·divider watchdog clock periods.
- R9: While `dbg_halt_i` and `freeze_en_i` are both high, the count and prescaler hold. When `freeze_en_i` is low, a halt has no effect.
- R10: Reset values: key reads 0, prescaler 0, reload 0xFFF, status 0, `rst_req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wdg_clk_i | input | 1 | Watchdog counting clock |
| hw_start_i | input | 1 | Strap that starts the watchdog in hardware |
| dbg_halt_i | input | 1 | Core-halted indication |
| freeze_en_i | input | 1 | Allows the halt to freeze the count |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| wdata_i | input | 16 | Bus write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| rst_req_o | output | 1 | Reset request, held until reset |

## Verification
The assertions check the following on every cycle:
- the reset request never drops once raised;
- a started watchdog never stops;
- the count never rises except on a reload or start;
- the count holds while frozen;
- the configuration shadows hold while access is locked;
- a configuration shadow holds while its update is in flight.

Only the bench scenarios can show the rest: the expiry time for each divider code and reload value, that random refresh spacing keeps the request low, that locked and busy writes are ignored as seen through read-back, and that the strap starts the count.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [1:0] ADDR_KEY    = 2'd0;
  localparam logic [1:0] ADDR_DIV    = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;
  // crossing channel indices
  localparam int CH_DIV   = 0;
  localparam int CH_RLD   = 1;
  localparam int CH_START = 2;
  localparam int CH_REFR  = 3;
  localparam int NUM_CH   = 4;
endpackage

// File: rtl/keyed_wdt_tog_sync.sv
module keyed_wdt_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic src_pulse_i,
  output logic busy_o,
  output logic dst_pulse_o
);
  logic              req_q;
  logic [STAGES-1:0] ack_sync;
  logic [STAGES-1:0] req_sync;
  logic              ack_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      ack_sync <= '0;
    end else begin
      req_q    <= req_q ^ (src_pulse_i & ~busy_o);
      ack_sync <= {ack_sync[STAGES-2:0], ack_q};
    end
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync <= '0;
      ack_q    <= 1'b0;
    end else begin
      req_sync <= {req_sync[STAGES-2:0], req_q};
      ack_q    <= req_sync[STAGES-1];
    end
  end

  assign dst_pulse_o = req_sync[STAGES-1] ^ ack_q;
  assign busy_o      = req_q ^ ack_sync[STAGES-1];
endmodule

// File: rtl/keyed_wdt_core.sv
module keyed_wdt_core #(
  parameter int CNT_W     = 12,
  parameter int PR_W      = 3,
  parameter int PS_W      = 8,
  parameter int MIN_SHIFT = 2
) (
  input  logic             wdg_clk_i,
  input  logic             rst_ni,
  input  logic             hw_start_i,
  input  logic             freeze_i,
  input  logic             start_p_i,
  input  logic             refresh_p_i,
  input  logic             div_p_i,
  input  logic             rld_p_i,
  input  logic [PR_W-1:0]  div_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             started_o
);
  localparam logic [PR_W-1:0] CODE_SAT = PR_W'(PS_W - MIN_SHIFT);

  logic             started_q, req_q;
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [PS_W-1:0]  ps_q, mask;
  logic [PR_W-1:0]  div_q, code_eff;
  logic             tick;

  always_comb begin
    code_eff = (div_q > CODE_SAT) ? CODE_SAT : div_q;
    mask     = PS_W'((32'd1 << (32'(code_eff) + MIN_SHIFT)) - 32'd1);
    tick     = started_q && !freeze_i && ((ps_q & mask) == mask);
  end

  always_ff @(posedge wdg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      req_q     <= 1'b0;
      cnt_q     <= '1;
      rld_q     <= '1;
      ps_q      <= '0;
      div_q     <= '0;
    end else begin
      if (div_p_i) div_q <= div_i;
      if (rld_p_i) rld_q <= rld_i;
      if (start_p_i || hw_start_i) started_q <= 1'b1;
      if (start_p_i && !started_q) begin
        cnt_q <= '1;
        ps_q  <= '0;
      end else if (refresh_p_i) begin
        cnt_q <= rld_q;
        ps_q  <= '0;
      end else begin
        if (started_q && !freeze_i) ps_q <= ps_q + 1'b1;
        if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      if (started_q && cnt_q == '0) req_q <= 1'b1;
    end
  end

  assign rst_req_o = req_q;
  assign cnt_o     = cnt_q;
  assign started_o = started_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PR_W        = 3,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdg_clk_i,
  input  logic             hw_start_i,
  input  logic             dbg_halt_i,
  input  logic             freeze_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [KEY_W-1:0] wdata_i,
  output logic [KEY_W-1:0] rdata_o,
  output logic             rst_req_o
);
  logic              unlock_q;
  logic [PR_W-1:0]   div_sh;
  logic [CNT_W-1:0]  rld_sh;
  logic [NUM_CH-1:0] src_p, busy, dst_p;
  logic              key_wr, div_wr, rld_wr, freeze_w, started_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              unused_busy;

  assign key_wr = wr_en_i && (addr_i == ADDR_KEY);
  assign div_wr = wr_en_i && (addr_i == ADDR_DIV) && unlock_q && !busy[CH_DIV];
  assign rld_wr = wr_en_i && (addr_i == ADDR_RELOAD) && unlock_q && !busy[CH_RLD];

  assign src_p[CH_DIV]   = div_wr;
  assign src_p[CH_RLD]   = rld_wr;
  assign src_p[CH_START] = key_wr && (wdata_i == KEY_START);
  assign src_p[CH_REFR]  = key_wr && (wdata_i == KEY_REFRESH);
  assign unused_busy     = ^busy[CH_REFR:CH_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      div_sh   <= '0;
      rld_sh   <= '1;
    end else begin
      if (key_wr) unlock_q <= (wdata_i == KEY_UNLOCK);
      if (div_wr) div_sh   <= wdata_i[PR_W-1:0];
      if (rld_wr) rld_sh   <= wdata_i[CNT_W-1:0];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_xing
    keyed_wdt_tog_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .src_clk_i  (clk_i),
      .dst_clk_i  (wdg_clk_i),
      .rst_ni     (rst_ni),
      .src_pulse_i(src_p[ch]),
      .busy_o     (busy[ch]),
      .dst_pulse_o(dst_p[ch])
    );
  end

  assign freeze_w = dbg_halt_i & freeze_en_i;

  keyed_wdt_core #(.CNT_W(CNT_W), .PR_W(PR_W), .PS_W(PS_W)) u_core (
    .wdg_clk_i  (wdg_clk_i),
    .rst_ni     (rst_ni),
    .hw_start_i (hw_start_i),
    .freeze_i   (freeze_w),
    .start_p_i  (dst_p[CH_START]),
    .refresh_p_i(dst_p[CH_REFR]),
    .div_p_i    (dst_p[CH_DIV]),
    .rld_p_i    (dst_p[CH_RLD]),
    .div_i      (div_sh),
    .rld_i      (rld_sh),
    .rst_req_o  (rst_req_o),
    .cnt_o      (cnt_w),
    .started_o  (started_w)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_DIV:    rdata_o = {{(KEY_W-PR_W){1'b0}}, div_sh};
      ADDR_RELOAD: rdata_o = {{(KEY_W-CNT_W){1'b0}}, rld_sh};
      ADDR_STAT:   rdata_o = {{(KEY_W-2){1'b0}}, busy[CH_RLD], busy[CH_DIV]};
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int CNT_W = 12,
  parameter int PR_W  = 3
) (
  input logic             clk_i,
  input logic             wdg_clk_i,
  input logic             rst_ni,
  input logic             unlock_q,
  input logic [PR_W-1:0]  div_sh,
  input logic [CNT_W-1:0] rld_sh,
  input logic [3:0]       busy,
  input logic [3:0]       dst_p,
  input logic [CNT_W-1:0] cnt_w,
  input logic             started_w,
  input logic             freeze_w,
  input logic             rst_req_o
);
  a_r2_req_held: assert property (@(posedge wdg_clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  a_r2_req_on_zero: assert property (@(posedge wdg_clk_i) disable iff (!rst_ni)
    (started_w && cnt_w == '0) |=> rst_req_o);
  a_r5_no_stop: assert property (@(posedge wdg_clk_i) disable iff (!rst_ni)
    started_w |=> started_w);
  a_r1_count_down: assert property (@(posedge wdg_clk_i) disable iff (!rst_ni)
    (started_w && !dst_p[3]) |=> (cnt_w <= $past(cnt_w)));
  a_r9_freeze_hold: assert property (@(posedge wdg_clk_i) disable iff (!rst_ni)
    (freeze_w && !dst_p[3] && !dst_p[2]) |=> $stable(cnt_w));
  a_r4_locked_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_q |=> ($stable(rld_sh) && $stable(div_sh)));
  a_r7_rld_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy[1] |=> $stable(rld_sh));
  a_r7_div_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy[0] |=> $stable(div_sh));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .PR_W(PR_W)) u_chk (
  .clk_i    (clk_i),
  .wdg_clk_i(wdg_clk_i),
  .rst_ni   (rst_ni),
  .unlock_q (unlock_q),
  .div_sh   (div_sh),
  .rld_sh   (rld_sh),
  .busy     (busy),
  .dst_p    (dst_p),
  .cnt_w    (cnt_w),
  .started_w(started_w),
  .freeze_w (freeze_w),
  .rst_req_o(rst_req_o)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  logic clk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
  logic hw_start = 1'b0, halt = 1'b0, frz_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #5   wclk = ~wclk;

  keyed_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wdg_clk_i(wclk), .hw_start_i(hw_start),
    .dbg_halt_i(halt), .freeze_en_i(frz_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(req)
  );

  function automatic int unsigned exp_div(input int unsigned code);
    return (code >= 6) ? 256 : (4 << code);
  endfunction

  // watchdog clock is half the bus clock rate
  function automatic int unsigned bus_cycles(input int unsigned ticks);
    return ticks * 2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(2'd3, s);
      if (s[1:0] == 2'b00) return;
    end
    check(1'b0, "R7 flags never cleared", 1, 0);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); rst_n = 1'b0; hw_start = strap; halt = 1'b0; frz_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic config_wdt(input int unsigned code, input int unsigned rld);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(code));
    wr(2'd2, 16'(rld));
    wait_idle();
  endtask

  // expiry expected ticks*2 bus cycles after the command; already_spent cycles elapsed
  task automatic check_expiry(input int unsigned ticks, input int unsigned spent, input string tag);
    int unsigned lo;
    lo = bus_cycles(ticks) - 2 - spent;
    repeat (lo) @(negedge clk);
    check(req == 1'b0, {tag, " early"}, req, 0);
    repeat (44) @(negedge clk);
    check(req == 1'b1, {tag, " late"}, req, 1);
  endtask

  initial begin
    logic [15:0] v, d;
    int unsigned r;
    r = $urandom(32'd91357);
    do_reset(1'b0);

    // R10 reset state
    rd(2'd0, v); check(v == 16'h0000, "R10 key read", v, 16'h0);
    rd(2'd1, v); check(v == 16'h0000, "R10 prescaler", v, 16'h0);
    rd(2'd2, v); check(v == 16'h0FFF, "R10 reload", v, 16'hFFF);
    rd(2'd3, v); check(v == 16'h0000, "R10 status", v, 16'h0);
    check(req == 1'b0, "R10 request", req, 0);

    // R4 locked writes ignored
    for (int i = 0; i < 6; i++) begin
      d = 16'($urandom);
      wr(2'd2, d); wr(2'd1, d);
      rd(2'd2, v); check(v == 16'h0FFF, "R4 locked reload", v, 16'hFFF);
      rd(2'd1, v); check(v == 16'h0000, "R4 locked prescaler", v, 16'h0);
    end

    // R7 busy flags and write-while-busy
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'h0040);
    rd(2'd3, v); check(v[1] == 1'b1, "R7 reload flag", v, 2);
    wr(2'd2, 16'h0123);
    wr(2'd1, 16'h0002);
    rd(2'd3, v); check(v[0] == 1'b1, "R7 prescaler flag", v, 1);
    wait_idle();
    rd(2'd2, v); check(v == 16'h0040, "R7 busy write dropped", v, 16'h40);

    // R4 random unlocked writes
    for (int i = 0; i < 4; i++) begin
      d = 16'($urandom);
      wr(2'd0, 16'h5555); wr(2'd2, d); wait_idle();
      rd(2'd2, v); check(v == {4'h0, d[11:0]}, "R4 unlocked reload", v, {4'h0, d[11:0]});
    end
    config_wdt(0, 16'h0040);
    rd(2'd1, v); check(v == 16'h0000, "R4 prescaler write", v, 0);
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'h0777);
    rd(2'd2, v); check(v == 16'h0040, "R4 relock by other key", v, 16'h40);

    // R3 random refresh spacing, divider 4, reload 0x40 -> 512 bus cycles
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hAAAA);
    for (int i = 0; i < 12; i++) begin
      repeat ($urandom % 400 + 16) @(negedge clk);
      check(req == 1'b0, "R3 refreshed no reset", req, 0);
      wr(2'd0, 16'hAAAA);
    end
    // R5 stop attempts after last refresh (3 writes = 6 cycles), then R2/R8 expiry
    wr(2'd0, 16'h5555); wr(2'd0, 16'h0000); wr(2'd0, 16'hCCCC);
    check_expiry(16'h40 * exp_div(0), 6, "R5 R8 expiry despite keys");
    wr(2'd0, 16'hAAAA);
    repeat (40) @(negedge clk);
    check(req == 1'b1, "R2 request held after refresh", req, 1);

    // R8 code 7 saturates at 256
    do_reset(1'b0);
    check(req == 1'b0, "R2 cleared by reset", req, 0);
    config_wdt(7, 3);
    wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
    check_expiry(3 * exp_div(7), 0, "R8 code 7");

    // R8 code 2 -> 16
    do_reset(1'b0);
    config_wdt(2, 8);
    wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
    check_expiry(8 * exp_div(2), 0, "R8 code 2");

    // R9 freeze holds count
    do_reset(1'b0);
    config_wdt(0, 16'h10);
    wr(2'd0, 16'hCCCC);
    frz_en = 1'b1; halt = 1'b1;
    wr(2'd0, 16'hAAAA);
    repeat (400) @(negedge clk);
    check(req == 1'b0, "R9 frozen no expiry", req, 0);
    halt = 1'b0;
    check_expiry(16'h10 * exp_div(0), 0, "R9 released");

    // R9 halt without enable keeps running
    do_reset(1'b0);
    config_wdt(0, 16'h10);
    frz_en = 1'b0; halt = 1'b1;
    wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
    check_expiry(16'h10 * exp_div(0), 0, "R9 halt ignored");

    // R1 software start from 0xFFF
    do_reset(1'b0);
    wr(2'd0, 16'hCCCC);
    check_expiry(4095 * exp_div(0), 0, "R1 start full count");

    // R6 hardware strap start
    do_reset(1'b1);
    check_expiry(4095 * exp_div(0), 0, "R6 strap start");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule